// File: doc/BRIEF.md
# Exception Recognition Timing Unit

This block sits next to the fetch/decode/execute sequencer of a small processor core. Each exception or interrupt source has its own recognition point in the instruction cycle. Memory faults are accepted at once. The edge-detected NMI is accepted as soon as it has been captured. Opcode faults are accepted in the decode phase and arithmetic faults in the execute phase. Trace and maskable interrupts wait for the instruction boundary. The sequencer marks the phases with three strobes and reads back one winning exception per cycle.

When several sources are eligible in the same cycle, a fixed priority picks one winner, and the other sources are held in pending latches. The outputs are combinational from the inputs and the pending state. They are a one-cycle taken flag, a 4-bit class code, the access tag of a memory fault, and an abort flag that tells the sequencer to drop the rest of the current instruction. Vector fetch and stacking belong to the sequencer.

Top module: `exc_timing_unit`

## Requirements
- R1: The NMI is edge-triggered. A low-to-high change of `nmi_pin`, sampled at a clock edge, makes the NMI pending after that edge. A pin that stays high produces no further request, and a pin already high when reset ends counts as no edge.
- R2: A pending NMI is taken (code 3) in the cycle after it was captured, whatever the phase strobes show. Taking it clears it, so `exc_take` with code 3 never lasts more than one cycle.
- R3: A maskable interrupt (code 11) is recognised only while `ph_bnd` is high, and only when `irq_req` and `irq_en` are both high there. A request seen without the enable, or outside the boundary, is not taken.
- R4: A bus error (code 1) or address error (code 2) is taken in the same cycle it is flagged, in any phase. Bus error beats address error. While either is taken, `exc_acc` carries `mem_acc` (0 fetch, 1 operand read, 2 write-back). Otherwise it is 0.
- R5: Illegal opcode (4), privilege violation (5), software interrupt (6) and overflow trap (7) are recognised only while `ph_dec` is high.
- R6: Divide by zero (8) and bounds violation (9) are recognised only while `ph_ex` is high.
- R7: A trace exception (code 10) is requested when `trace_en` is high at `ph_bnd`, and it is taken only at a boundary.
- R8: Among the eligible sources, the lowest code wins. The decode, execute, trace and interrupt requests that lose remain pending. A pending decode or execute fault is eligible in any later cycle. A pending trace or interrupt is eligible only at a boundary.
- R9: `abort_insn` is high exactly when an exception is taken while `ph_bnd` is low.
- R10: After reset nothing is pending. When `exc_take` is low, `exc_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| nmi_pin | input | 1 | Non-maskable interrupt pin, edge-sensitive |
| irq_req | input | 1 | Maskable peripheral interrupt request |
| irq_en | input | 1 | Maskable interrupt enable |
| bus_err | input | 1 | Bus error on the current access |
| addr_err | input | 1 | Address error on the current access |
| mem_acc | input | 2 | Access type of the faulting access |
| dec_priv | input | 1 | Decoded privilege violation |
| dec_swi | input | 1 | Decoded software interrupt instruction |
| dec_ovf | input | 1 | Decoded overflow-trap instruction that traps |
| dec_ill | input | 1 | Illegal or unimplemented opcode |
| ex_div0 | input | 1 | Divide by zero in execute |
| ex_bound | input | 1 | Bounds check failed in execute |
| trace_en | input | 1 | Single-step trace enable |
| ph_dec | input | 1 | Decode phase strobe |
| ph_ex | input | 1 | Execute phase strobe |
| ph_bnd | input | 1 | Instruction boundary strobe |
| exc_take | output | 1 | Exception taken this cycle |
| exc_code | output | 4 | Class code of the taken exception |
| exc_acc | output | 2 | Access tag of a taken memory fault |
| abort_insn | output | 1 | Cancel the rest of the current instruction |

## Verification
Each fault flag is driven once inside its own phase and once outside it. This separates a phase gate that works from one that is missing or inverted.

A stepped NMI is applied in three ways: held high, released, and raised again together with a bus error and a decode fault. This shows edge capture against level sensing and shows that pending sources survive a loss. Combined requests show whether the priority order and the boundary-only eligibility of trace and interrupt are right. Pairs of boundary and mid-instruction takes show whether the abort flag follows the phase.

// File: rtl/exc_timing_unit.sv
module exc_timing_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nmi_pin,
  input  logic       irq_req,
  input  logic       irq_en,
  input  logic       bus_err,
  input  logic       addr_err,
  input  logic [1:0] mem_acc,
  input  logic       dec_priv,
  input  logic       dec_swi,
  input  logic       dec_ovf,
  input  logic       dec_ill,
  input  logic       ex_div0,
  input  logic       ex_bound,
  input  logic       trace_en,
  input  logic       ph_dec,
  input  logic       ph_ex,
  input  logic       ph_bnd,
  output logic       exc_take,
  output logic [3:0] exc_code,
  output logic [1:0] exc_acc,
  output logic       abort_insn
);
  localparam int NCLS = 11;

  logic            nmi_q, nmi_pend;
  logic [NCLS:4]   pend;
  logic [NCLS:1]   fresh, elig, win;

  assign fresh[1]  = bus_err;
  assign fresh[2]  = addr_err;
  assign fresh[3]  = 1'b0;
  assign fresh[4]  = ph_dec & dec_ill;
  assign fresh[5]  = ph_dec & dec_priv;
  assign fresh[6]  = ph_dec & dec_swi;
  assign fresh[7]  = ph_dec & dec_ovf;
  assign fresh[8]  = ph_ex  & ex_div0;
  assign fresh[9]  = ph_ex  & ex_bound;
  assign fresh[10] = ph_bnd & trace_en;
  assign fresh[11] = ph_bnd & irq_en & irq_req;

  assign elig[3:1]   = {nmi_pend, fresh[2:1]};
  assign elig[9:4]   = fresh[9:4] | pend[9:4];
  assign elig[11:10] = ph_bnd ? (fresh[11:10] | pend[11:10]) : 2'b00;

  assign win = elig & (~elig + 11'd1);

  always_comb begin
    exc_code = 4'd0;
    for (int i = NCLS; i >= 1; i--)
      if (win[i]) exc_code = 4'(i);
  end

  assign exc_take   = |elig;
  assign abort_insn = exc_take & ~ph_bnd;
  assign exc_acc    = (win[1] | win[2]) ? mem_acc : 2'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q    <= 1'b1;
      nmi_pend <= 1'b0;
      pend     <= '0;
    end else begin
      nmi_q    <= nmi_pin;
      nmi_pend <= (nmi_pend & ~win[3]) | (nmi_pin & ~nmi_q);
      pend     <= (pend | fresh[NCLS:4]) & ~win[NCLS:4];
    end
  end
endmodule

// File: rtl/exc_timing_chk.sv
module exc_timing_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       nmi_pin,
  input logic       irq_req,
  input logic       irq_en,
  input logic       bus_err,
  input logic       addr_err,
  input logic [1:0] mem_acc,
  input logic       dec_priv,
  input logic       dec_swi,
  input logic       dec_ovf,
  input logic       dec_ill,
  input logic       ex_div0,
  input logic       ex_bound,
  input logic       trace_en,
  input logic       ph_dec,
  input logic       ph_ex,
  input logic       ph_bnd,
  input logic       exc_take,
  input logic [3:0] exc_code,
  input logic [1:0] exc_acc,
  input logic       abort_insn
);
  a_r2_nmi_single: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && exc_code == 4'd3) |=> !(exc_take && exc_code == 4'd3));

  a_r3_irq_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && exc_code == 4'd11) |-> ph_bnd);

  a_r7_trace_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && exc_code == 4'd10) |-> ph_bnd);

  a_r4_bus_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (exc_take && exc_code == 4'd1 && exc_acc == mem_acc));

  a_r5_decode_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!ph_dec && !bus_err && !addr_err && exc_take && exc_code >= 4'd4 && exc_code <= 4'd7)
      |-> $past(exc_take));

  a_r9_abort_mid: assert property (@(posedge clk) disable iff (!rst_n)
    abort_insn |-> (exc_take && !ph_bnd));

  a_r9_abort_needed: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && !ph_bnd) |-> abort_insn);

  a_r10_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_take |-> (exc_code == 4'd0 && !abort_insn));
endmodule

bind exc_timing_unit exc_timing_chk u_chk (.*);

// File: tb/exc_timing_unit_bench.sv
module exc_timing_unit_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic nmi_pin, irq_req, irq_en, bus_err, addr_err;
  logic [1:0] mem_acc;
  logic dec_priv, dec_swi, dec_ovf, dec_ill, ex_div0, ex_bound, trace_en;
  logic ph_dec, ph_ex, ph_bnd;
  logic exc_take, abort_insn;
  logic [3:0] exc_code;
  logic [1:0] exc_acc;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  exc_timing_unit u_exc_timing_unit (.*);

  localparam logic [16:0] NMI = 17'h10000, IRQ = 17'h08000, IEN = 17'h04000,
    BUS = 17'h02000, ADR = 17'h01000, AC1 = 17'h00800, AC0 = 17'h00400,
    PRV = 17'h00200, SWI = 17'h00100, OVF = 17'h00080, ILL = 17'h00040,
    DV0 = 17'h00020, BND = 17'h00010, TRC = 17'h00008, PD = 17'h00004,
    PE = 17'h00002, PB = 17'h00001;
  localparam int NV = 29;

  localparam logic [16:0] VIN [NV] = '{
    17'h0, PD|ILL, PE|DV0, PE|BND, PD|PRV|SWI, 17'h0, ILL, PB|TRC,
    PB|IRQ|IEN, PB|IRQ, IRQ|IEN, BUS|AC0, ADR|AC1, BUS|ADR, NMI, NMI,
    NMI, 17'h0, NMI|BUS, NMI|BUS|PD|ILL, NMI, NMI, NMI|PB|TRC|IRQ|IEN,
    PB, PD|OVF, PB|TRC|IRQ|IEN, 17'h0, PB, 17'h0};

  localparam logic [4:0] VEX [NV] = '{
    {4'd0,1'b0}, {4'd4,1'b1}, {4'd8,1'b1}, {4'd9,1'b1}, {4'd5,1'b1},
    {4'd6,1'b1}, {4'd0,1'b0}, {4'd10,1'b0}, {4'd11,1'b0}, {4'd0,1'b0},
    {4'd0,1'b0}, {4'd1,1'b1}, {4'd2,1'b1}, {4'd1,1'b1}, {4'd0,1'b0},
    {4'd3,1'b1}, {4'd0,1'b0}, {4'd0,1'b0}, {4'd1,1'b1}, {4'd1,1'b1},
    {4'd3,1'b1}, {4'd4,1'b1}, {4'd10,1'b0}, {4'd11,1'b0}, {4'd7,1'b1},
    {4'd10,1'b0}, {4'd0,1'b0}, {4'd11,1'b0}, {4'd0,1'b0}};

  string tag [NV] = '{
    "R10", "R5", "R6", "R6", "R8", "R8", "R5", "R7",
    "R3", "R3", "R3", "R4", "R4", "R4", "R1", "R2",
    "R1", "R1", "R4", "R8", "R2", "R8", "R8",
    "R3", "R9", "R7", "R3", "R3", "R10"};

  task automatic apply(input logic [16:0] v);
    {nmi_pin, irq_req, irq_en, bus_err, addr_err, mem_acc, dec_priv, dec_swi,
     dec_ovf, dec_ill, ex_div0, ex_bound, trace_en, ph_dec, ph_ex, ph_bnd} = v;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #1600000;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    apply(17'h0);
    repeat (3) @(negedge clk);
    #3 check("R10 reset state", {exc_take, exc_code, abort_insn, exc_acc}, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VIN[i]);
      #3 check(tag[i], {exc_take, exc_code, abort_insn, 2'b00},
               {VEX[i][4:1] != 4'd0, VEX[i], 2'b00});
    end

    // R4: access tag passed through with a write-back fault, cleared otherwise
    @(negedge clk); apply(BUS|AC1);
    #3 check("R4 tag", {6'd0, exc_acc}, 8'd2);
    @(negedge clk); apply(PD|ILL|AC1);
    #3 check("R4 tag idle", {2'd0, exc_code, exc_acc}, {2'd0, 4'd4, 2'd0});

    // R1: NMI captured but reset before it is taken; a high pin after reset is no edge
    @(negedge clk); apply(17'h0);
    @(negedge clk); apply(NMI);
    @(negedge clk); rst_n = 1'b0;
    #3 check("R10 reset clears", {7'd0, exc_take}, 8'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    #3 check("R1 no edge after reset", {7'd0, exc_take}, 8'd0);
    @(negedge clk);
    #3 check("R1 held high", {7'd0, exc_take}, 8'd0);

    // R2: NMI taken at a boundary carries no abort
    @(negedge clk); apply(17'h0);
    @(negedge clk); apply(NMI|PB);
    @(negedge clk);
    #3 check("R2 nmi at boundary", {exc_take, exc_code, abort_insn, 2'b00},
             {1'b1, 4'd3, 1'b0, 2'b00});
    @(negedge clk); apply(NMI);
    #3 check("R2 cleared", {7'd0, exc_take}, 8'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule